// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block lets a small CPU reprogram its own paged program flash. Software writes a command code into an 8-bit control register. That write arms the command for a short window of cycles. If the CPU's store-to-program-memory strobe arrives inside the window, the command runs. If it does not, the arm state lapses and a later strobe does nothing. Two commands exist. A load command places one 16-bit data word into a temporary page buffer. A page-write command copies the whole buffer into one flash page.

The byte address pointer is split into three fields. The high field picks the page. The middle field picks the word inside that page. Bit 0 picks the byte of a word, and only byte reads of program memory use it. A page write lasts a fixed number of cycles. For that whole time the block holds the CPU halted. When the write ends, the block pulses a done output and resets the buffer to all-ones. An EEPROM write request throws away whatever has been loaded into the buffer so far. The flash array is a behavioural memory that takes a whole page at once when the write latency has passed.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset, `halt` is 0, `done` is 0 and `ctl_rdata` reads 8'h00.
- R2: Writing 8'h01 or 8'h05 to the control register arms that command, and bit 0 of `ctl_rdata` (the enable bit) reads 1. A strobe on `spm_strobe` on any of the ARM_WIN (4) clock cycles after the write cycle is accepted. If no strobe comes in that window, the enable bit reads 0 from the cycle after the last window cycle, and any later strobe is ignored. Buffer contents are kept when the window lapses.
- R3: Code 8'h01 followed by an accepted strobe stores `wdata` into buffer word `zptr[5:1]`. The enable bit then clears and `ctl_rdata` reads 8'h00.
- R4: Code 8'h05 followed by an accepted strobe programs the page selected by `zptr[11:6]` with the buffer contents. During this command `zptr[5:0]` and `wdata` are ignored.
- R5: `halt` is 1 from the cycle after the accepted page-write strobe, for exactly WR_LAT (16) cycles.
- R6: `done` is a single-cycle pulse in the first cycle where `halt` is low again. From that cycle on, the new page contents can be read.
- R7: A byte read (`lpm_rd`) returns, one cycle later on `lpm_data`, byte `zptr[0]` of word `zptr[11:1]`. A value of 1 in `zptr[0]` selects the high byte.
- R8: When a page write completes, every buffer word becomes 16'hFFFF. In the `done` cycle the enable bit reads 0, so `ctl_rdata` reads 8'h04.
- R9: An `ee_we` pulse outside a page write resets every buffer word to 16'hFFFF. If it falls in the same cycle as an accepted load strobe, the discard wins and that word is not stored.
- R10: A control write with any other code is stored with bit 0 forced to 0 and arms nothing. A strobe that follows it changes neither the buffer nor `halt`.
- R11: While `halt` is 1, control writes, strobes and `ee_we` are ignored. The write still ends on time, and the buffer contents taken at the start are programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register contents |
| spm_strobe | input | 1 | Store-to-program-memory strobe |
| zptr | input | 12 | Byte address pointer: page, word, byte fields |
| wdata | input | 16 | Data word for a buffer load |
| ee_we | input | 1 | EEPROM write request |
| lpm_rd | input | 1 | Program memory byte read request |
| lpm_data | output | 8 | Byte read result, one cycle after the request |
| halt | output | 1 | CPU stall during a page write |
| done | output | 1 | One-cycle pulse when a page write completes |

## Verification
An EEPROM write request and an accepted buffer-load strobe can land on the same clock edge. The bench provokes this by raising `ee_we` together with the load strobe inside an open arm window. It sandwiches that cycle between loads on either side, then programs the page and reads every affected word back. The result counts as correct if the words loaded before the discard and the word of the colliding load read 16'hFFFF, while words loaded afterwards hold their data. A second overlap is a control write arriving in the middle of a page write. It is judged by the exact length of `halt` and by the control value read at `done`.

// File: rtl/flash_sp_pkg.sv
package flash_sp_pkg;
  localparam logic [7:0] CMD_LOAD = 8'h01;
  localparam logic [7:0] CMD_PGWR = 8'h05;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_t;

  function automatic logic is_cmd(input logic [7:0] v);
    return (v == CMD_LOAD) || (v == CMD_PGWR);
  endfunction
endpackage

// File: rtl/sp_cmd_arm.sv
module sp_cmd_arm
  import flash_sp_pkg::*;
#(
  parameter int ARM_WIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       spm_strobe,
  input  logic       busy,
  input  logic       wr_commit,
  output logic [7:0] ctl_q,
  output logic       fire_load,
  output logic       fire_write
);
  localparam int CW = $clog2(ARM_WIN + 1);

  logic [CW-1:0] win_q, win_d;
  logic [7:0]    ctl_d;
  logic          armed, accept;

  assign armed      = (win_q != '0);
  assign accept     = armed & spm_strobe & ~ctl_we & ~busy;
  assign fire_load  = accept & (ctl_q == CMD_LOAD);
  assign fire_write = accept & (ctl_q == CMD_PGWR);

  always_comb begin
    ctl_d = ctl_q;
    win_d = win_q;
    if (busy) begin
      if (wr_commit) ctl_d[0] = 1'b0;
    end else if (ctl_we) begin
      if (is_cmd(ctl_wdata)) begin
        ctl_d = ctl_wdata;
        win_d = CW'(ARM_WIN);
      end else begin
        ctl_d = {ctl_wdata[7:1], 1'b0};
        win_d = '0;
      end
    end else if (accept) begin
      win_d = '0;
      if (ctl_q == CMD_LOAD) ctl_d[0] = 1'b0;
    end else if (armed) begin
      win_d = win_q - CW'(1);
      if (win_q == CW'(1)) ctl_d[0] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 8'h00;
      win_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      win_q <= win_d;
    end
  end
endmodule

// File: rtl/sp_write_seq.sv
module sp_write_seq
  import flash_sp_pkg::*;
#(
  parameter int PAGE_W = 6,
  parameter int WR_LAT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_write,
  input  logic [PAGE_W-1:0] page_in,
  output logic              busy,
  output logic              commit,
  output logic [PAGE_W-1:0] page_q,
  output logic              done
);
  localparam int LW = (WR_LAT > 1) ? $clog2(WR_LAT) : 1;

  seq_state_t        st_q, st_d;
  logic [LW-1:0]     lat_q, lat_d;
  logic              page_en;

  assign busy   = (st_q == SEQ_BUSY);
  assign commit = busy && (lat_q == LW'(WR_LAT - 1));

  always_comb begin
    st_d    = st_q;
    lat_d   = lat_q;
    page_en = 1'b0;
    if (!busy) begin
      if (fire_write) begin
        st_d    = SEQ_BUSY;
        lat_d   = '0;
        page_en = 1'b1;
      end
    end else if (commit) begin
      st_d = SEQ_IDLE;
    end else begin
      lat_d = lat_q + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      lat_q  <= '0;
      page_q <= '0;
      done   <= 1'b0;
    end else begin
      st_q  <= st_d;
      lat_q <= lat_d;
      done  <= commit;
      if (page_en) page_q <= page_in;
    end
  end
endmodule

// File: rtl/sp_page_buf.sv
module sp_page_buf #(
  parameter int WORDS = 32,
  parameter int DW    = 16,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire_load,
  input  logic [WORD_W-1:0]         word_idx,
  input  logic [DW-1:0]             wdata,
  input  logic                      discard,
  input  logic                      commit,
  output logic [WORDS-1:0][DW-1:0]  page_data
);
  logic clr;
  assign clr = discard | commit;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] w_q;
    logic          w_en;
    assign w_en = clr | (fire_load && (word_idx == WORD_W'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= '1;
      else if (w_en) w_q <= clr ? '1 : wdata;
    end
    assign page_data[g] = w_q;
  end
endmodule

// File: rtl/sp_flash_mem.sv
module sp_flash_mem #(
  parameter int PAGES = 64,
  parameter int WORDS = 32,
  parameter int DW    = 16,
  localparam int PAGE_W = $clog2(PAGES),
  localparam int WORD_W = $clog2(WORDS),
  localparam int AW     = PAGE_W + WORD_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [PAGE_W-1:0]        page_q,
  input  logic [WORDS-1:0][DW-1:0] page_data,
  input  logic                     lpm_rd,
  input  logic [AW-1:0]            rd_idx,
  input  logic                     byte_sel,
  output logic [7:0]               lpm_data
);
  logic [DW-1:0] mem [PAGES*WORDS];
  logic [DW-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int w = 0; w < WORDS; w++) begin
        mem[{page_q, WORD_W'(w)}] <= page_data[w];
      end
    end
  end

  assign rd_word = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lpm_data <= 8'h00;
    else if (lpm_rd) lpm_data <= byte_sel ? rd_word[15:8] : rd_word[7:0];
  end
endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import flash_sp_pkg::*;
#(
  parameter int PAGES   = 64,
  parameter int WORDS   = 32,
  parameter int WR_LAT  = 16,
  parameter int ARM_WIN = 4,
  parameter int DW      = 16,
  localparam int PAGE_W = $clog2(PAGES),
  localparam int WORD_W = $clog2(WORDS),
  localparam int ZW     = PAGE_W + WORD_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          spm_strobe,
  input  logic [ZW-1:0] zptr,
  input  logic [DW-1:0] wdata,
  input  logic          ee_we,
  input  logic          lpm_rd,
  output logic [7:0]    lpm_data,
  output logic          halt,
  output logic          done
);
  logic [1:0]              rs_q;
  logic                    rst_core_n;
  logic                    fire_load, fire_write;
  logic                    busy, commit, discard;
  logic [PAGE_W-1:0]       page_q;
  logic [WORDS-1:0][DW-1:0] page_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign discard = ee_we & ~busy;
  assign halt    = busy;

  sp_cmd_arm #(.ARM_WIN(ARM_WIN)) u_arm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .spm_strobe (spm_strobe),
    .busy       (busy),
    .wr_commit  (commit),
    .ctl_q      (ctl_rdata),
    .fire_load  (fire_load),
    .fire_write (fire_write)
  );

  sp_write_seq #(.PAGE_W(PAGE_W), .WR_LAT(WR_LAT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .fire_write (fire_write),
    .page_in    (zptr[ZW-1:WORD_W+1]),
    .busy       (busy),
    .commit     (commit),
    .page_q     (page_q),
    .done       (done)
  );

  sp_page_buf #(.WORDS(WORDS), .DW(DW)) u_buf (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .fire_load  (fire_load),
    .word_idx   (zptr[WORD_W:1]),
    .wdata      (wdata),
    .discard    (discard),
    .commit     (commit),
    .page_data  (page_data)
  );

  sp_flash_mem #(.PAGES(PAGES), .WORDS(WORDS), .DW(DW)) u_mem (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .commit     (commit),
    .page_q     (page_q),
    .page_data  (page_data),
    .lpm_rd     (lpm_rd),
    .rd_idx     (zptr[ZW-1:1]),
    .byte_sel   (zptr[0]),
    .lpm_data   (lpm_data)
  );
endmodule

// File: rtl/flash_selfprog_ctrl_chk.sv
module flash_selfprog_ctrl_chk #(
  parameter int ARM_WIN = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       spm_strobe,
  input logic       halt,
  input logic       done
);
  localparam int SW = $clog2(ARM_WIN + 2);
  logic [SW-1:0] since_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       since_wr <= SW'(ARM_WIN);
    else if (ctl_we)                  since_wr <= '0;
    else if (since_wr < SW'(ARM_WIN)) since_wr <= since_wr + SW'(1);
  end

  AST_LATE_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (spm_strobe && !ctl_we && !halt && since_wr >= SW'(ARM_WIN)) |=> !halt); // R2

  AST_WRITE_RAISES_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (spm_strobe && !ctl_we && !halt && since_wr < SW'(ARM_WIN) && ctl_rdata == 8'h05) |=> halt); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_ENDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!halt && $past(halt))); // R6

  AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ctl_rdata[0]); // R8

  AST_BAD_CODE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !halt && ctl_wdata != 8'h01 && ctl_wdata != 8'h05)
      |=> (ctl_rdata == {$past(ctl_wdata[7:1]), 1'b0})); // R10
endmodule

bind flash_selfprog_ctrl flash_selfprog_ctrl_chk #(.ARM_WIN(ARM_WIN)) u_chk (.*);

// File: tb/flash_selfprog_ctrl_test.sv
`timescale 1ns/1ps
module flash_selfprog_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic        ctl_we;
  logic [7:0]  ctl_wdata;
  logic [7:0]  ctl_rdata;
  logic        spm_strobe;
  logic [11:0] zptr;
  logic [15:0] wdata;
  logic        ee_we;
  logic        lpm_rd;
  logic [7:0]  lpm_data;
  logic        halt;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  flash_selfprog_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .spm_strobe(spm_strobe), .zptr(zptr), .wdata(wdata),
    .ee_we(ee_we), .lpm_rd(lpm_rd), .lpm_data(lpm_data), .halt(halt), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] addr(input int page, input int word, input bit b);
    return {page[5:0], word[4:0], b};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic spm(input logic [11:0] z, input logic [15:0] d, input bit ee);
    spm_strobe = 1'b1; zptr = z; wdata = d; ee_we = ee;
    @(negedge clk);
    spm_strobe = 1'b0; ee_we = 1'b0;
  endtask

  task automatic load(input int page, input int word, input logic [15:0] d, input int dly);
    ctl_write(8'h01);
    idle(dly);
    spm(addr(page, word, 0), d, 1'b0);
    chk(ctl_rdata == 8'h00, "R3", "ctl after load", ctl_rdata, 8'h00);
  endtask

  task automatic page_write(input int page, input int jw, input logic [15:0] jd);
    ctl_write(8'h05);
    spm(addr(page, jw, 1), jd, 1'b0);
    chk(halt == 1'b1, "R5", "halt first cycle", halt, 1);
    for (int i = 2; i <= 16; i++) begin
      @(negedge clk);
      chk(halt && !done, "R5", "halt held", {halt, done}, 2'b10);
    end
    @(negedge clk);
    chk(done && !halt, "R6", "done with halt low", {halt, done}, 2'b01);
    chk(ctl_rdata == 8'h04, "R8", "ctl at done", ctl_rdata, 8'h04);
    @(negedge clk);
    chk(!done, "R6", "done single pulse", done, 0);
  endtask

  task automatic read_word(input int page, input int word, output logic [15:0] v);
    lpm_rd = 1'b1; zptr = addr(page, word, 0);
    @(negedge clk);
    v[7:0] = lpm_data;
    zptr = addr(page, word, 1);
    @(negedge clk);
    v[15:8] = lpm_data;
    lpm_rd = 1'b0;
  endtask

  task automatic expect_word(input int page, input int word, input logic [15:0] e,
                             input string req);
    logic [15:0] v;
    read_word(page, word, v);
    chk(v == e, req, $sformatf("flash p%0d w%0d", page, word), v, e);
  endtask

  task automatic t_reset;
    chk(halt == 1'b0, "R1", "halt after reset", halt, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(ctl_rdata == 8'h00, "R1", "ctl after reset", ctl_rdata, 8'h00);
  endtask

  task automatic t_load_write;
    load(5, 0, 16'h1234, 0);
    load(5, 1, 16'hBEEF, 3);
    load(5, 31, 16'h0F0F, 1);
    page_write(5, 7, 16'hDEAD);
    expect_word(5, 0, 16'h1234, "R7");
    expect_word(5, 1, 16'hBEEF, "R2");
    expect_word(5, 31, 16'h0F0F, "R3");
    expect_word(5, 7, 16'hFFFF, "R4");
    expect_word(5, 2, 16'hFFFF, "R4");
  endtask

  task automatic t_window;
    load(9, 3, 16'hA5A5, 0);
    ctl_write(8'h05);
    chk(ctl_rdata == 8'h05, "R2", "armed enable", ctl_rdata, 8'h05);
    idle(3);
    chk(ctl_rdata == 8'h05, "R2", "still armed", ctl_rdata, 8'h05);
    idle(1);
    chk(ctl_rdata == 8'h04, "R2", "window lapsed", ctl_rdata, 8'h04);
    spm(addr(9, 0, 0), 16'h0000, 1'b0);
    chk(halt == 1'b0, "R2", "late strobe no halt", halt, 0);
    idle(2);
    chk(halt == 1'b0, "R2", "late strobe no halt later", halt, 0);
    page_write(9, 0, 16'h0000);
    expect_word(9, 3, 16'hA5A5, "R2");
  endtask

  task automatic t_discard;
    load(12, 1, 16'h1111, 0);
    load(12, 2, 16'h2222, 0);
    ee_we = 1'b1;
    @(negedge clk);
    ee_we = 1'b0;
    load(12, 5, 16'h5555, 0);
    ctl_write(8'h01);
    spm(addr(12, 3, 0), 16'h3333, 1'b1);
    load(12, 4, 16'h4444, 0);
    page_write(12, 0, 16'h0000);
    expect_word(12, 1, 16'hFFFF, "R9");
    expect_word(12, 2, 16'hFFFF, "R9");
    expect_word(12, 5, 16'hFFFF, "R9");
    expect_word(12, 3, 16'hFFFF, "R9");
    expect_word(12, 4, 16'h4444, "R9");
  endtask

  task automatic t_bad_code;
    ctl_write(8'h03);
    chk(ctl_rdata == 8'h02, "R10", "bad code stored", ctl_rdata, 8'h02);
    spm(addr(20, 6, 0), 16'h7777, 1'b0);
    chk(halt == 1'b0, "R10", "no halt", halt, 0);
    chk(ctl_rdata == 8'h02, "R10", "ctl unchanged", ctl_rdata, 8'h02);
    page_write(20, 0, 16'h0000);
    expect_word(20, 6, 16'hFFFF, "R10");
    expect_word(20, 4, 16'hFFFF, "R8");
  endtask

  task automatic t_busy;
    int n;
    load(30, 0, 16'h3030, 0);
    ctl_write(8'h05);
    spm(addr(30, 0, 0), 16'h0000, 1'b0);
    chk(halt == 1'b1, "R5", "busy start", halt, 1);
    idle(2);
    ctl_write(8'h01);
    spm(addr(30, 1, 0), 16'h9999, 1'b1);
    n = 0;
    while (!done && n < 30) begin
      @(negedge clk);
      n++;
    end
    chk(n == 12, "R11", "write length unchanged", n, 12);
    chk(ctl_rdata == 8'h04, "R11", "ctl write ignored", ctl_rdata, 8'h04);
    idle(1);
    expect_word(30, 0, 16'h3030, "R11");
    expect_word(30, 1, 16'hFFFF, "R11");
  endtask

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = 8'h00; spm_strobe = 1'b0;
    zptr = '0; wdata = '0; ee_we = 1'b0; lpm_rd = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_load_write;
    t_window;
    t_discard;
    t_bad_code;
    t_busy;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule